// File: doc/BRIEF.md
# One-Time-Programmable Configuration Memory SPI Target

This block is a synthesizable device model of a serial configuration memory whose cells can only ever be set. A host talks to it over a four-wire SPI link in mode 0, where each transaction is one chip-select frame. The first byte of a frame is the command, and the bytes after it carry an address, data, or dummy cycles. The memory is split into three regions: a main array of parameterized depth, a trim region made of four eight-byte rows, and a sixteen-byte signature region whose first byte is a fixed chip identifier.

The target stays locked after reset. It does nothing until a six-byte access key arrives within a single frame. Once unlocked, the host can do the following:

- switch program-enable on or off;
- pick the active region through a register write at a fixed address;
- write eight bytes at a time;
- stream reads with an auto-incrementing address;
- poll a status byte.

After an eight-byte write is accepted, the status byte reports busy for a programmable number of system clocks. Every write ORs its data into the stored bytes, so a bit that has been set can never return to zero. A memory-side debug port reads any region combinationally, so that a test environment or a neighbouring block can inspect the array directly.

SCK, CS_n and MOSI are sampled through two-flop synchronizers in the system clock domain. SCK must therefore run slower than about one eighth of the system clock.

Top module: `otp_cfg_target`

## Requirements
- R1: Until one frame carries the bytes 7E AA 99 7E 01 0E as its first six bytes, every other command is ignored: no write, no enable change, and MISO reads 0x00. A key that is split across two frames does not unlock the target.
- R2: Bytes are shifted MSB first in SPI mode 0. MOSI is taken on the rising SCK edge and MISO changes on the falling edge. Raising CS_n discards all frame state, and MISO is 0 while CS_n is high.
- R3: Command 0x02 is followed by a 3-byte address (MSB first) and 8 data bytes, which land at the address and the next seven addresses of the selected region. Each byte is committed as it arrives, and main addresses at or above the depth are ignored.
- R4: A write stores the old byte OR the new byte. Erased bytes read 0x00, and writing 0x00 leaves the contents unchanged.
- R5: Command 0x06 sets program-enable and 0x04 clears it. A 0x02 write received while program-enable is clear changes nothing and starts no busy period.
- R6: Command 0x83 with address 0x000025 and data 0x00, 0x10 or 0x20 selects main, trim or signature respectively. Any other address or data value leaves the selection unchanged.
- R7: Command 0x03 is followed by a 3-byte address and 9 dummy bytes. Every byte after that returns the selected region at the address, incrementing by one per byte while CS_n stays low.
- R8: Command 0x05 returns status on every byte after the command. Bits 7 and 0 are 1 for BUSY_CLKS clocks after the eighth data byte of an enabled write, bit 1 is program-enable, and all other bits are 0.
- R9: The trim region holds rows at 0x20, 0x60, 0xA0 and 0xE0, each eight bytes long. Any other trim address reads 0x00 and ignores writes.
- R10: Command 0x84 uses the same framing as 0x03 but always reads the trim region, whichever region is selected.
- R11: Signature byte 0 reads CHIP_ID (default 0x20) and no write changes it. Signature bytes 1 to 15 are writable.
- R12: The debug port returns, in the same cycle, the byte at dbg_addr in region dbg_bank (0 main, 1 trim, 2 signature).

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| dbg_bank | input | 2 | Debug read region: 0 main, 1 trim, 2 signature |
| dbg_addr | input | 24 | Debug read byte address |
| dbg_data | output | 8 | Debug read data |

## Verification
The embedded assertions check the following on every cycle:

- no array write while the target is locked or program-enable is clear;
- every main-array update keeps all previously set bits;
- the signature identifier cell is never written;
- the region selector never holds an unused code;
- the busy counter never exceeds its limit;
- MISO is idle and no byte completes outside a frame.

Only the directed scenarios can show frame-level behaviour:

- key matching across frame boundaries;
- the 9-dummy-byte read latency and auto-increment;
- status timing around a write;
- trim row addressing;
- reads of the trim region that bypass the selected region;
- discarding of aborted frames.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;

    typedef enum logic [1:0] {
        BANK_MAIN = 2'd0,
        BANK_TRIM = 2'd1,
        BANK_SIG  = 2'd2,
        BANK_RSVD = 2'd3
    } bank_e;

    typedef logic [4:0] idx_t;

    typedef struct packed {
        logic        en;
        bank_e       bank;
        logic [23:0] addr;
        logic [7:0]  data;
    } wr_req_t;

    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_PGM_OFF = 8'h04;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_PGM_ON  = 8'h06;
    localparam logic [7:0] OP_BANKSEL = 8'h83;
    localparam logic [7:0] OP_TRIM_RD = 8'h84;

    localparam logic [23:0] BANKSEL_ADDR = 24'h000025;
    localparam logic [7:0]  CODE_MAIN    = 8'h00;
    localparam logic [7:0]  CODE_TRIM    = 8'h10;
    localparam logic [7:0]  CODE_SIG     = 8'h20;

    localparam int   ADDR_BYTES  = 3;
    localparam int   DUMMY_BYTES = 9;
    localparam int   WR_BYTES    = 8;
    localparam int   KEY_LEN     = 6;
    localparam idx_t IDX_ADDR_LO = idx_t'(ADDR_BYTES);
    localparam idx_t IDX_WR0     = idx_t'(ADDR_BYTES + 1);
    localparam idx_t IDX_WR_LAST = idx_t'(ADDR_BYTES + WR_BYTES);
    localparam idx_t IDX_DATA    = idx_t'(1 + ADDR_BYTES + DUMMY_BYTES);
    localparam idx_t IDX_KEY_END = idx_t'(KEY_LEN - 1);
    localparam idx_t IDX_MAX     = '1;

    function automatic logic [7:0] key_byte(input idx_t i);
        case (i)
            5'd0:    return 8'h7E;
            5'd1:    return 8'hAA;
            5'd2:    return 8'h99;
            5'd3:    return 8'h7E;
            5'd4:    return 8'h01;
            5'd5:    return 8'h0E;
            default: return 8'h00;
        endcase
    endfunction

    // Trim rows live where bit 5 is set and bits 4:3 are clear.
    function automatic logic trim_hit(input logic [23:0] a);
        return (a[23:8] == 16'd0) && a[5] && (a[4:3] == 2'b00);
    endfunction

    function automatic logic [4:0] trim_index(input logic [23:0] a);
        return {a[7:6], a[2:0]};
    endfunction

    function automatic logic sig_hit(input logic [23:0] a);
        return a[23:4] == 20'd0;
    endfunction

    function automatic logic [7:0] pack_status(input logic busy, input logic pgm);
        return {busy, 5'b00000, pgm, busy};
    endfunction

endpackage

// File: rtl/otp_spi_sync.sv
module otp_spi_sync (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [1:0] sck_p, cs_p, mo_p;
    logic       sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= 2'b00;
            cs_p  <= 2'b11;
            mo_p  <= 2'b00;
            sck_q <= 1'b0;
        end else begin
            sck_p <= {sck_p[0], sck_i};
            cs_p  <= {cs_p[0], cs_n_i};
            mo_p  <= {mo_p[0], mosi_i};
            sck_q <= sck_p[1];
        end
    end

    assign cs_act   = !cs_p[1];
    assign sck_rise = cs_act && sck_p[1] && !sck_q;
    assign sck_fall = cs_act && !sck_p[1] && sck_q;
    assign mosi_s   = mo_p[1];
endmodule

// File: rtl/otp_byte_shifter.sv
module otp_byte_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_act,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_load,
    output logic       miso
);
    logic [2:0] bitcnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       seen_byte;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bitcnt    <= 3'd0;
            rx_sh     <= 7'd0;
            tx_sh     <= 8'd0;
            seen_byte <= 1'b0;
            rx_valid  <= 1'b0;
            rx_byte   <= 8'd0;
            tx_load   <= 1'b0;
            miso      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            if (sck_rise) begin
                rx_sh  <= {rx_sh[5:0], mosi_s};
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    rx_valid  <= 1'b1;
                    rx_byte   <= {rx_sh, mosi_s};
                    seen_byte <= 1'b1;
                end
            end
            if (sck_fall) begin
                if (bitcnt == 3'd0 && seen_byte) begin
                    miso    <= tx_byte[7];
                    tx_sh   <= {tx_byte[6:0], 1'b0};
                    tx_load <= 1'b1;
                end else begin
                    miso  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    // R2
    rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(cs_act));
    // R2
    idle_miso_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !miso);
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
    import otp_cfg_pkg::*;
#(
    parameter int BUSY_CLKS = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_act,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                tx_load,
    output logic [7:0]          tx_byte,
    output otp_cfg_pkg::bank_e  rd_bank,
    output logic [23:0]         rd_addr,
    input  logic [7:0]          rd_data,
    output otp_cfg_pkg::wr_req_t wr
);
    localparam int BW = $clog2(BUSY_CLKS + 1);

    logic          unlocked, pgm_en, key_ok;
    bank_e         sel_bank;
    logic [7:0]    cmd;
    idx_t          idx;
    logic [23:0]   addr, rd_ptr;
    logic [BW-1:0] busy_cnt;
    logic          busy, is_read;

    assign busy    = busy_cnt != '0;
    assign is_read = (cmd == OP_READ) || (cmd == OP_TRIM_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            pgm_en   <= 1'b0;
            key_ok   <= 1'b1;
            sel_bank <= BANK_MAIN;
            cmd      <= 8'd0;
            idx      <= '0;
            addr     <= 24'd0;
            rd_ptr   <= 24'd0;
            busy_cnt <= '0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (!cs_act) begin
                idx    <= '0;
                cmd    <= 8'd0;
                key_ok <= 1'b1;
                addr   <= 24'd0;
            end else begin
                if (rx_valid) begin
                    if (idx != IDX_MAX) idx <= idx + 5'd1;
                    if (idx <= IDX_KEY_END) begin
                        if (rx_byte != key_byte(idx)) key_ok <= 1'b0;
                        if (idx == IDX_KEY_END && key_ok && rx_byte == key_byte(idx))
                            unlocked <= 1'b1;
                    end
                    if (idx == '0) cmd <= rx_byte;
                    if (unlocked) begin
                        if (idx == '0 && rx_byte == OP_PGM_ON)  pgm_en <= 1'b1;
                        if (idx == '0 && rx_byte == OP_PGM_OFF) pgm_en <= 1'b0;
                        if (idx != '0 && idx <= IDX_ADDR_LO)
                            addr <= {addr[15:0], rx_byte};
                        if (idx == IDX_ADDR_LO)
                            rd_ptr <= {addr[15:0], rx_byte};
                        if (cmd == OP_WRITE && idx >= IDX_WR0 && idx <= IDX_WR_LAST) begin
                            wr.en   <= pgm_en;
                            wr.bank <= sel_bank;
                            wr.addr <= addr + {19'd0, idx - IDX_WR0};
                            wr.data <= rx_byte;
                            if (idx == IDX_WR_LAST && pgm_en)
                                busy_cnt <= BW'(BUSY_CLKS);
                        end
                        if (cmd == OP_BANKSEL && idx == IDX_WR0 && addr == BANKSEL_ADDR) begin
                            case (rx_byte)
                                CODE_MAIN: sel_bank <= BANK_MAIN;
                                CODE_TRIM: sel_bank <= BANK_TRIM;
                                CODE_SIG:  sel_bank <= BANK_SIG;
                                default:   ;
                            endcase
                        end
                    end
                end
                if (tx_load && unlocked && is_read && idx >= IDX_DATA)
                    rd_ptr <= rd_ptr + 24'd1;
            end
        end
    end

    always_comb begin
        tx_byte = 8'h00;
        if (unlocked) begin
            if (cmd == OP_STATUS && idx != '0)
                tx_byte = pack_status(busy, pgm_en);
            else if (is_read && idx >= IDX_DATA)
                tx_byte = rd_data;
        end
    end

    assign rd_bank = (cmd == OP_TRIM_RD) ? BANK_TRIM : sel_bank;
    assign rd_addr = rd_ptr;

    // R1
    locked_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> !wr.en);
    // R5
    pgm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(pgm_en));
    // R6
    bank_legal_chk: assert property (@(posedge clk) disable iff (rst)
        sel_bank != BANK_RSVD);
    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= BW'(BUSY_CLKS));
endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_cfg_pkg::*;
#(
    parameter int         MAIN_DEPTH = 256,
    parameter logic [7:0] CHIP_ID    = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  otp_cfg_pkg::wr_req_t wr,
    input  otp_cfg_pkg::bank_e   rd_bank,
    input  logic [23:0]          rd_addr,
    output logic [7:0]           rd_data,
    input  otp_cfg_pkg::bank_e   dbg_bank,
    input  logic [23:0]          dbg_addr,
    output logic [7:0]           dbg_data
);
    localparam int MAIN_AW    = (MAIN_DEPTH > 1) ? $clog2(MAIN_DEPTH) : 1;
    localparam int TRIM_BYTES = 32;
    localparam int SIG_BYTES  = 16;
    localparam int NPORTS     = 2;

    logic [7:0] main_mem [MAIN_DEPTH];
    logic [7:0] trim_mem [TRIM_BYTES];
    logic [7:0] sig_mem  [SIG_BYTES];

    logic               main_we, trim_we, sig_we;
    logic [MAIN_AW-1:0] main_wi;
    logic [7:0]         main_old;

    assign main_wi  = wr.addr[MAIN_AW-1:0];
    assign main_we  = wr.en && wr.bank == BANK_MAIN && (wr.addr < 24'(MAIN_DEPTH));
    assign trim_we  = wr.en && wr.bank == BANK_TRIM && trim_hit(wr.addr);
    assign sig_we   = wr.en && wr.bank == BANK_SIG && sig_hit(wr.addr) && (wr.addr[3:0] != 4'd0);
    assign main_old = main_mem[main_wi];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAIN_DEPTH; i++) main_mem[i] <= 8'h00;
            for (int i = 0; i < TRIM_BYTES; i++) trim_mem[i] <= 8'h00;
            for (int i = 0; i < SIG_BYTES; i++)  sig_mem[i]  <= 8'h00;
        end else begin
            if (main_we) main_mem[main_wi] <= main_old | wr.data;
            if (trim_we) trim_mem[trim_index(wr.addr)] <= trim_mem[trim_index(wr.addr)] | wr.data;
            if (sig_we)  sig_mem[wr.addr[3:0]] <= sig_mem[wr.addr[3:0]] | wr.data;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rport
        bank_e       b;
        logic [23:0] a;
        logic [7:0]  v;
        assign b = (p == 0) ? rd_bank : dbg_bank;
        assign a = (p == 0) ? rd_addr : dbg_addr;
        always_comb begin
            v = 8'h00;
            case (b)
                BANK_MAIN: if (a < 24'(MAIN_DEPTH)) v = main_mem[a[MAIN_AW-1:0]];
                BANK_TRIM: if (trim_hit(a)) v = trim_mem[trim_index(a)];
                BANK_SIG:  if (sig_hit(a)) v = (a[3:0] == 4'd0) ? CHIP_ID : sig_mem[a[3:0]];
                default:   v = 8'h00;
            endcase
        end
        if (p == 0) begin : g_host
            assign rd_data = v;
        end else begin : g_dbg
            assign dbg_data = v;
        end
    end

    // R4
    set_only_chk: assert property (@(posedge clk) disable iff (rst)
        main_we |=> ((main_mem[$past(main_wi)] & $past(main_old)) == $past(main_old)));
    // R11
    id_cell_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        sig_mem[0] == 8'h00);
endmodule

// File: rtl/otp_cfg_target.sv
module otp_cfg_target
    import otp_cfg_pkg::*;
#(
    parameter int         MAIN_DEPTH = 256,
    parameter int         BUSY_CLKS  = 1000,
    parameter logic [7:0] CHIP_ID    = 8'h20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic [1:0]  dbg_bank,
    input  logic [23:0] dbg_addr,
    output logic [7:0]  dbg_data
);
    logic        cs_act, sck_rise, sck_fall, mosi_s;
    logic        rx_valid, tx_load;
    logic [7:0]  rx_byte, tx_byte, rd_data;
    bank_e       rd_bank;
    logic [23:0] rd_addr;
    wr_req_t     wr;

    otp_spi_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    otp_byte_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .tx_byte  (tx_byte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_load  (tx_load),
        .miso     (spi_miso)
    );

    otp_cmd_ctrl #(.BUSY_CLKS(BUSY_CLKS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .rd_bank  (rd_bank),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr       (wr)
    );

    otp_store #(.MAIN_DEPTH(MAIN_DEPTH), .CHIP_ID(CHIP_ID)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_bank  (rd_bank),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .dbg_bank (bank_e'(dbg_bank)),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );
endmodule

// File: tb/otp_cfg_target_bench.sv
module otp_cfg_target_bench;
    localparam int HALF = 8;
    localparam int BUSY = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [1:0]  dbg_bank = 2'd0;
    logic [23:0] dbg_addr = 24'd0;
    logic [7:0]  dbg_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] tx_buf [0:31];
    logic [7:0] rx_buf [0:31];
    logic [7:0] wdat   [0:7];
    logic [7:0] trim20 [0:7];

    always #5 clk = ~clk;

    otp_cfg_target #(.MAIN_DEPTH(256), .BUSY_CLKS(BUSY), .CHIP_ID(8'h20)) u_otp_cfg_target (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dbg_bank(dbg_bank), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input int n, input bit close = 1'b1);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_buf[b][i];
                repeat (HALF) @(negedge clk);
                rx_buf[b][i] = miso;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        if (close) cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] c);
        tx_buf[0] = c;
        spi_xfer(1);
    endtask

    task automatic send_key();
        tx_buf[0] = 8'h7E; tx_buf[1] = 8'hAA; tx_buf[2] = 8'h99;
        tx_buf[3] = 8'h7E; tx_buf[4] = 8'h01; tx_buf[5] = 8'h0E;
        spi_xfer(6);
    endtask

    task automatic wr8(input logic [23:0] a);
        tx_buf[0] = 8'h02; tx_buf[1] = a[23:16]; tx_buf[2] = a[15:8]; tx_buf[3] = a[7:0];
        for (int i = 0; i < 8; i++) tx_buf[4 + i] = wdat[i];
        spi_xfer(12);
    endtask

    task automatic rd(input logic [7:0] c, input logic [23:0] a, input int n);
        tx_buf[0] = c; tx_buf[1] = a[23:16]; tx_buf[2] = a[15:8]; tx_buf[3] = a[7:0];
        for (int i = 4; i < 13 + n; i++) tx_buf[i] = 8'h00;
        spi_xfer(13 + n);
    endtask

    task automatic bank_sel(input logic [7:0] code, input logic [23:0] a);
        tx_buf[0] = 8'h83; tx_buf[1] = a[23:16]; tx_buf[2] = a[15:8]; tx_buf[3] = a[7:0];
        tx_buf[4] = code;
        spi_xfer(5);
    endtask

    task automatic get_status(output logic [7:0] s);
        tx_buf[0] = 8'h05; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
        spi_xfer(3);
        s = rx_buf[1];
    endtask

    task automatic peek(input logic [1:0] b, input logic [23:0] a, output logic [7:0] v);
        @(negedge clk);
        dbg_bank = b;
        dbg_addr = a;
        #1;
        v = dbg_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R2 miso idle after reset", {7'd0, miso}, 8'h00);
        peek(2'd0, 24'h0, v); chk("R12 main erased", v, 8'h00);
        peek(2'd2, 24'h0, v); chk("R11 chip id", v, 8'h20);
    endtask

    task automatic t_locked();
        logic [7:0] v, s;
        for (int i = 0; i < 8; i++) wdat[i] = 8'hFF;
        cmd1(8'h06);
        wr8(24'h000010);
        peek(2'd0, 24'h10, v); chk("R1 write ignored while locked", v, 8'h00);
        get_status(s); chk("R1 status reads zero while locked", s, 8'h00);
        tx_buf[0] = 8'h7E; tx_buf[1] = 8'hAA; tx_buf[2] = 8'h99; spi_xfer(3);
        tx_buf[0] = 8'h7E; tx_buf[1] = 8'h01; tx_buf[2] = 8'h0E; spi_xfer(3);
        cmd1(8'h06);
        get_status(s); chk("R1 split key keeps lock", s, 8'h00);
    endtask

    task automatic t_unlock_disabled_write();
        logic [7:0] v, s;
        send_key();
        get_status(s); chk("R8 status after unlock, pgm off", s, 8'h00);
        for (int i = 0; i < 8; i++) wdat[i] = 8'hA5;
        wr8(24'h000010);
        peek(2'd0, 24'h10, v); chk("R5 write with pgm off ignored", v, 8'h00);
        get_status(s); chk("R5 no busy after disabled write", s, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v, s;
        cmd1(8'h06);
        get_status(s); chk("R5 pgm enable shown in bit 1", s, 8'h02);
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h11 * (i + 1));
        wr8(24'h000010);
        get_status(s); chk("R8 busy right after write", s, 8'h83);
        chk("R8 status repeats on later byte", rx_buf[2], 8'h83);
        for (int i = 0; i < 8; i++) begin
            peek(2'd0, 24'(16 + i), v); chk("R3 byte landed", v, 8'(8'h11 * (i + 1)));
        end
        repeat (BUSY + 100) @(negedge clk);
        get_status(s); chk("R8 busy clears", s, 8'h02);
        rd(8'h03, 24'h000010, 10);
        for (int i = 0; i < 8; i++) chk("R7 read data", rx_buf[13 + i], 8'(8'h11 * (i + 1)));
        chk("R7 auto-increment past data", rx_buf[21], 8'h00);
        chk("R7 dummy bytes read zero", rx_buf[12], 8'h00);
        for (int i = 0; i < 8; i++) wdat[i] = 8'h3C;
        wr8(24'h0000FC);
        peek(2'd0, 24'hFF, v); chk("R3 last in-range byte", v, 8'h3C);
        rd(8'h03, 24'h0000FF, 2);
        chk("R3 in-range read", rx_buf[13], 8'h3C);
        chk("R3 beyond depth reads zero", rx_buf[14], 8'h00);
    endtask

    task automatic t_or();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) wdat[i] = 8'hF0;
        wr8(24'h000010);
        peek(2'd0, 24'h10, v); chk("R4 OR into byte 0", v, 8'hF1);
        peek(2'd0, 24'h13, v); chk("R4 OR into byte 3", v, 8'hF4);
        for (int i = 0; i < 8; i++) wdat[i] = 8'h00;
        wr8(24'h000010);
        peek(2'd0, 24'h12, v); chk("R4 zero write keeps bits", v, 8'hF3);
    endtask

    task automatic t_pgm_off();
        logic [7:0] v, s;
        repeat (BUSY + 100) @(negedge clk);
        cmd1(8'h04);
        for (int i = 0; i < 8; i++) wdat[i] = 8'hFF;
        wr8(24'h000020);
        peek(2'd0, 24'h20, v); chk("R5 disabled write no effect", v, 8'h00);
        get_status(s); chk("R5 pgm cleared, not busy", s, 8'h00);
    endtask

    task automatic t_trim();
        logic [7:0] v;
        cmd1(8'h06);
        bank_sel(8'h10, 24'h000025);
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h40 + i);
        wr8(24'h000060);
        for (int i = 0; i < 8; i++) begin
            wdat[i] = 8'(8'hC0 + i);
            trim20[i] = 8'(8'hC0 + i);
        end
        wr8(24'h000020);
        for (int i = 0; i < 8; i++) wdat[i] = 8'hFF;
        wr8(24'h000040);
        peek(2'd1, 24'h63, v); chk("R9 trim row at 0x60", v, 8'h43);
        peek(2'd0, 24'h63, v); chk("R6 main untouched by trim write", v, 8'h00);
        peek(2'd1, 24'h40, v); chk("R9 gap address ignored", v, 8'h00);
        rd(8'h03, 24'h000060, 1);
        chk("R6 read follows trim selection", rx_buf[13], 8'h40);
        bank_sel(8'h20, 24'h000026);
        bank_sel(8'h30, 24'h000025);
        for (int i = 0; i < 8; i++) wdat[i] = 8'h5A;
        wr8(24'h0000A0);
        peek(2'd1, 24'hA0, v); chk("R6 bad select leaves trim", v, 8'h5A);
        peek(2'd2, 24'h00, v); chk("R6 bad select leaves sig", v, 8'h20);
    endtask

    task automatic t_trim_read();
        bank_sel(8'h00, 24'h000025);
        rd(8'h84, 24'h000020, 8);
        for (int i = 0; i < 8; i++) chk("R10 trim read bypasses bank", rx_buf[13 + i], trim20[i]);
        rd(8'h03, 24'h000020, 1);
        chk("R6 main selected again", rx_buf[13], 8'h00);
    endtask

    task automatic t_sig();
        logic [7:0] v;
        bank_sel(8'h20, 24'h000025);
        for (int i = 0; i < 8; i++) wdat[i] = 8'hFF;
        wr8(24'h000000);
        peek(2'd2, 24'h00, v); chk("R11 id byte unchanged", v, 8'h20);
        peek(2'd2, 24'h01, v); chk("R11 other sig byte writable", v, 8'hFF);
        rd(8'h03, 24'h000000, 2);
        chk("R11 id via read", rx_buf[13], 8'h20);
        chk("R11 sig byte 1 via read", rx_buf[14], 8'hFF);
    endtask

    task automatic t_abort();
        logic [7:0] s;
        tx_buf[0] = 8'h03; tx_buf[1] = 8'h00;
        spi_xfer(2);
        chk("R2 miso idle between frames", {7'd0, miso}, 8'h00);
        repeat (BUSY + 100) @(negedge clk);
        get_status(s); chk("R2 fresh frame after abort", s, 8'h02);
        tx_buf[0] = 8'hA5;
        spi_xfer(1);
        chk("R2 MSB-first command decode (0xA5 is no-op)", {7'd0, miso}, 8'h00);
        get_status(s); chk("R2 status unchanged by unknown byte", s, 8'h02);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_locked();
        t_unlock_disabled_write();
        t_write_read();
        t_or();
        t_pgm_off();
        t_trim();
        t_trim_read();
        t_sig();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule